// File: doc/BRIEF.md
# Fixed-Period Winding Current Chopper

This block regulates the current in one motor winding by chopping an H-bridge at a fixed rate. Each chopping period has a fixed length in clock cycles. At the start of every period the block turns the bridge on in the commanded polarity. It then waits for a digital over-threshold comparator to report that the winding current has reached its target. For a blanking window at the start of drive the comparator is not looked at, so switching noise cannot end the pulse early. This window also sets the shortest possible on-time.

Once the threshold is reached, the bridge leaves drive and spends the rest of the period in one of three decay styles, chosen by a 2-bit select:
- **Slow decay** shorts the winding through both low-side switches.
- **Fast decay** drives the bridge in reverse until a zero-current flag is seen, then opens every switch.
- **Mixed decay** applies only while the stepping table says the current is falling. It starts as fast decay and switches to slow decay at three quarters of the period. When the current is not falling, mixed decay behaves as slow decay.

A commanded magnitude of zero keeps the bridge off for the whole period. The four outputs control the high-side and low-side switches of the two half-bridges. They are registered, and they never switch on both devices of one half-bridge together. Comparator, DAC and dead-time insertion live outside this block.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after any cycle with `en` low, all four gate outputs are 0. The first enabled clock edge after that starts a new period.
- R2: A period lasts PERIOD_CYC clocks. On its first clock the bridge drives forward in the polarity latched at that edge. Polarity 1 means `hs_a`=1 and `ls_b`=1. Polarity 0 means `hs_b`=1 and `ls_a`=1.
- R3: Drive lasts at least BLANK_CYC clocks. A comparator trip is ignored in period cycles 0 to BLANK_CYC-2. A trip seen from cycle BLANK_CYC-1 onward is honoured.
- R4: Once a trip is honoured, drive ends at the next clock edge and decay holds until the period ends.
- R5: Select code 2'b00 (slow) recirculates the current: `ls_a`=`ls_b`=1 and both high sides are off.
- R6: Select code 2'b11 (fast) drives in reverse polarity. At the first clock edge with `zero_i` high, all gates turn off for the rest of the period.
- R7: Select codes 2'b01 and 2'b10 (mixed) decide at decay entry, using `falling`. If `falling` is high and the period count has not reached MIX_CYC = 3*PERIOD_CYC/4, decay starts as fast decay and changes to slow decay when the count reaches MIX_CYC. It changes earlier to all-off if `zero_i` is seen first. If `falling` is low, slow decay is used.
- R8: `hs_a` and `ls_a` are never both 1, and `hs_b` and `ls_b` are never both 1.
- R9: If `zero_cmd` is high at the first edge of a period, all gates stay 0 for that whole period.
- R10: Changes of `pol` in the middle of a period have no effect on the gates until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bridge enable; low forces all gates off |
| pol | input | 1 | Winding polarity, sampled at period start |
| falling | input | 1 | Table current is decreasing |
| zero_i | input | 1 | Winding current is near zero |
| trip | input | 1 | Sense comparator over threshold |
| decay_sel | input | 2 | 00 slow, 11 fast, 01/10 mixed |
| zero_cmd | input | 1 | Commanded magnitude is zero |
| hs_a | output | 1 | High-side gate, half-bridge A |
| ls_a | output | 1 | Low-side gate, half-bridge A |
| hs_b | output | 1 | High-side gate, half-bridge B |
| ls_b | output | 1 | Low-side gate, half-bridge B |

## Verification
The assertions assume that BLANK_CYC is at least 1 and smaller than MIX_CYC. They also assume that all inputs are synchronous to `clk`, so a value sampled at an edge is the value the logic acted on.

The stimulus keeps to these assumptions: every input changes only on the falling clock edge, and the bench parameters keep blanking well below the three-quarter point. Trip, zero flag and polarity are changed almost every cycle. This stresses the blanking window, the latched polarity and the order of priority between the zero flag and the mixed-decay handover.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_DRIVE = 3'd1,
    PH_FASTF = 3'd2,
    PH_FASTM = 3'd3,
    PH_SLOW  = 3'd4,
    PH_COAST = 3'd5
  } phase_t;

  localparam logic [1:0] DK_SLOW = 2'b00;
  localparam logic [1:0] DK_FAST = 2'b11;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int PERIOD_CYC = 1667,
  localparam int CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  assign wrap    = (cnt == LAST);
  assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= LAST;
    else            cnt <= cnt_nxt;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> (cnt == $past(cnt) + 1'b1) || !$past(en));
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 1667,
  parameter int BLANK_CYC  = 208,
  localparam int CW      = $clog2(PERIOD_CYC),
  localparam int MIX_CYC = (3 * PERIOD_CYC) / 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          wrap,
  input  logic          trip,
  input  logic          zero_i,
  input  logic          falling,
  input  logic [1:0]    decay_sel,
  input  logic          zero_cmd,
  input  logic          pol,
  output phase_t        ph_q,
  output phase_t        ph_n,
  output logic          pol_n
);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] MIX_PT     = CW'(MIX_CYC);

  logic   pol_q;
  phase_t decay_entry;

  always_comb begin
    if (decay_sel == DK_SLOW)      decay_entry = PH_SLOW;
    else if (decay_sel == DK_FAST) decay_entry = PH_FASTF;
    else if (falling && cnt_nxt < MIX_PT) decay_entry = PH_FASTM;
    else                           decay_entry = PH_SLOW;
  end

  always_comb begin
    pol_n = pol_q;
    ph_n  = ph_q;
    if (!en) begin
      ph_n = PH_OFF;
    end else if (wrap) begin
      ph_n  = zero_cmd ? PH_OFF : PH_DRIVE;
      pol_n = pol;
    end else begin
      unique case (ph_q)
        PH_DRIVE: if (trip && cnt >= BLANK_LAST) ph_n = decay_entry;
        PH_FASTF: if (zero_i) ph_n = PH_COAST;
        PH_FASTM: if (zero_i) ph_n = PH_COAST;
                  else if (cnt_nxt >= MIX_PT) ph_n = PH_SLOW;
        default:  ph_n = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_OFF;
      pol_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      pol_q <= pol_n;
    end
  end

  p_blank_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (en && ph_q == PH_DRIVE && cnt < BLANK_LAST) |=> ph_q == PH_DRIVE);
  p_start_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (en && wrap && !zero_cmd) |=> ph_q == PH_DRIVE);
  p_zero_cmd_off_r9: assert property (@(posedge clk) disable iff (rst)
    (en && wrap && zero_cmd) |=> ph_q == PH_OFF);
  p_slow_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap && ph_q == PH_SLOW) |=> ph_q == PH_SLOW);
  p_pol_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(pol_q));
  p_mix_window_r7: assert property (@(posedge clk) disable iff (rst)
    ph_q == PH_FASTM |-> cnt < MIX_PT);
endmodule

// File: rtl/chop_gates.sv
module chop_gates
  import chop_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t ph_n,
  input  logic   pol_n,
  output logic   hs_a,
  output logic   ls_a,
  output logic   hs_b,
  output logic   ls_b
);
  logic [3:0] g_n;  // {hs_a, ls_a, hs_b, ls_b}

  always_comb begin
    unique case (ph_n)
      PH_DRIVE:          g_n = pol_n ? 4'b1001 : 4'b0110;
      PH_FASTF, PH_FASTM: g_n = pol_n ? 4'b0110 : 4'b1001;
      PH_SLOW:           g_n = 4'b0101;
      default:           g_n = 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) {hs_a, ls_a, hs_b, ls_b} <= 4'b0000;
    else     {hs_a, ls_a, hs_b, ls_b} <= g_n;
  end

  p_no_shoot_r8: assert property (@(posedge clk) disable iff (rst)
    !(hs_a && ls_a) && !(hs_b && ls_b));
  p_slow_lowside_r5: assert property (@(posedge clk) disable iff (rst)
    (ph_n == PH_SLOW) |=> (ls_a && ls_b && !hs_a && !hs_b));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 1667,
  parameter int BLANK_CYC  = 208,
  localparam int CW = $clog2(PERIOD_CYC)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       pol,
  input  logic       falling,
  input  logic       zero_i,
  input  logic       trip,
  input  logic [1:0] decay_sel,
  input  logic       zero_cmd,
  output logic       hs_a,
  output logic       ls_a,
  output logic       hs_b,
  output logic       ls_b
);
  logic [CW-1:0] cnt, cnt_nxt;
  logic          wrap;
  phase_t        ph_q, ph_n;
  logic          pol_n;

  chop_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(en),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  chop_seq #(.PERIOD_CYC(PERIOD_CYC), .BLANK_CYC(BLANK_CYC)) u_seq (
    .clk(clk), .rst(rst), .en(en),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap),
    .trip(trip), .zero_i(zero_i), .falling(falling),
    .decay_sel(decay_sel), .zero_cmd(zero_cmd), .pol(pol),
    .ph_q(ph_q), .ph_n(ph_n), .pol_n(pol_n)
  );

  chop_gates u_gates (
    .clk(clk), .rst(rst), .ph_n(ph_n), .pol_n(pol_n),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  p_dis_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(hs_a || ls_a || hs_b || ls_b));
  p_cmd_zero_off_r9: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_OFF) |-> !(hs_a || ls_a || hs_b || ls_b));
endmodule

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;
  localparam int P   = 40;
  localparam int BL  = 6;
  localparam int MIX = (3 * P) / 4;

  localparam int M_OFF = 0, M_DRV = 1, M_FF = 2, M_FM = 3, M_SLOW = 4, M_COAST = 5;

  logic clk = 0, rst = 1, en = 0, pol = 0, falling = 0, zero_i = 0, trip = 0, zero_cmd = 0;
  logic [1:0] decay_sel = 2'b00;
  logic hs_a, ls_a, hs_b, ls_b;

  int checks = 0, errors = 0;
  int mc, mph, mpol;

  always #2.5 clk = ~clk;

  chop_ctrl #(.PERIOD_CYC(P), .BLANK_CYC(BL)) dut (
    .clk(clk), .rst(rst), .en(en), .pol(pol), .falling(falling),
    .zero_i(zero_i), .trip(trip), .decay_sel(decay_sel), .zero_cmd(zero_cmd),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  function automatic logic [3:0] exp_gates(int ph, int p);
    case (ph)
      M_DRV:        return p ? 4'b1001 : 4'b0110;
      M_FF, M_FM:   return p ? 4'b0110 : 4'b1001;
      M_SLOW:       return 4'b0101;
      default:      return 4'b0000;
    endcase
  endfunction

  function automatic string tag_of(int ph);
    case (ph)
      M_DRV:   return "R2/R3/R10";
      M_FF:    return "R6/R4";
      M_FM:    return "R7";
      M_SLOW:  return "R5/R7";
      M_COAST: return "R6";
      default: return "R1/R9";
    endcase
  endfunction

  // advance the reference by one clock edge using the current inputs
  task automatic model_step();
    int nc;
    if (rst || !en) begin
      mc = P - 1; mph = M_OFF;
      if (rst) mpol = 0;
    end else if (mc == P - 1) begin
      mc = 0; mph = zero_cmd ? M_OFF : M_DRV; mpol = pol;
    end else begin
      nc = mc + 1;
      case (mph)
        M_DRV: if (trip && mc >= BL - 1) begin
          if (decay_sel == 2'b00)      mph = M_SLOW;
          else if (decay_sel == 2'b11) mph = M_FF;
          else if (falling && nc < MIX) mph = M_FM;
          else                         mph = M_SLOW;
        end
        M_FF: if (zero_i) mph = M_COAST;
        M_FM: if (zero_i) mph = M_COAST; else if (nc >= MIX) mph = M_SLOW;
        default: ;
      endcase
      mc = nc;
    end
  endtask

  task automatic check_now(string tag);
    logic [3:0] act, ex;
    act = {hs_a, ls_a, hs_b, ls_b};
    ex  = exp_gates(mph, mpol);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: gates actual %b expected %b (count %0d)", tag, act, ex, mc);
    end
    checks++;
    if ((hs_a && ls_a) || (hs_b && ls_b)) begin
      errors++;
      $display("FAIL R8: gates actual %b expected no same-leg pair", act);
    end
  endtask

  // one cycle: inputs already set; edge, then compare at falling edge
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_now(tag_of(mph));
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    cyc(); cyc();
    checks++;
    if ({hs_a, ls_a, hs_b, ls_b} !== 4'b0000) begin
      errors++; $display("FAIL R1: reset gates actual %b expected 0000", {hs_a, ls_a, hs_b, ls_b});
    end
    rst = 0;
    cyc();
    // directed R3: trip held high from period start, forward drive must last BL cycles
    en = 1; pol = 1; trip = 1; decay_sel = 2'b00;
    begin
      int drv = 0;
      for (int i = 0; i < P; i++) begin
        cyc();
        if (hs_a && ls_b) drv++;
      end
      checks++;
      if (drv != BL) begin
        errors++; $display("FAIL R3: drive cycles actual %0d expected %0d", drv, BL);
      end
    end
    // directed R6: fast decay with no zero flag, then zero flag
    trip = 0; decay_sel = 2'b11;
    for (int i = 0; i < P; i++) begin
      trip = (mc >= 10);
      zero_i = (mc == 20);
      cyc();
    end
    // directed R7: mixed, falling, long fast then handover; and non-falling
    decay_sel = 2'b01; falling = 1; zero_i = 0;
    for (int i = 0; i < 2 * P; i++) begin
      trip = (mc >= 8);
      if (i == P) falling = 0;
      cyc();
    end
    // directed R9 and R10
    zero_cmd = 1;
    for (int i = 0; i < P; i++) begin trip = 0; cyc(); zero_cmd = 0; end
    for (int i = 0; i < P; i++) begin pol = i[0]; trip = (i > 20); cyc(); end
    // directed R1: disable mid-drive
    trip = 0;
    for (int i = 0; i < 5; i++) cyc();
    en = 0; cyc(); cyc();
    checks++;
    if ({hs_a, ls_a, hs_b, ls_b} !== 4'b0000) begin
      errors++; $display("FAIL R1: disabled gates actual %b expected 0000", {hs_a, ls_a, hs_b, ls_b});
    end
    en = 1;
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      trip   = ($urandom % 6) == 0;
      zero_i = ($urandom % 14) == 0;
      pol    = $urandom % 2;
      if (($urandom % 30) == 0) decay_sel = 2'($urandom % 4);
      if (($urandom % 25) == 0) falling = $urandom % 2;
      zero_cmd = ($urandom % 50) == 0;
      if (($urandom % 300) == 0) en = 0;
      else if (!en && ($urandom % 3) == 0) en = 1;
      cyc();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule